// File: doc/BRIEF.md
# Floating-point control and status register

This block holds the floating-point unit's control state: a 3-bit dynamic rounding mode and five sticky exception flags. Software reaches the same state through one access port with three views: the whole 32-bit register, the rounding-mode field alone, or the flag field alone. An access can be a plain read or an atomic swap. A swap returns the old contents of the selected view in the same cycle and writes the new value at the next clock edge. The arithmetic datapath reports fresh exception flags each cycle on a separate input, and the block ORs them into the stored flags.

The block also turns an issuing instruction's 3-bit rounding field into the rounding mode that takes effect. A field value of 111 picks the stored dynamic mode. The block raises an illegal-encoding output whenever the resulting mode is one of the reserved codes. The static and dynamic paths each have their own set of reserved codes.

Top module: `fp_ctl_csr`

## Requirements
- R1: A synchronous active-high reset clears the rounding mode and all flags to zero, so a full-view read after reset returns 0.
- R2: A full-view read (view code 0) returns the rounding mode in bits 7..5 and the flags in bits 4..0. Bits 31..8 always read as zero, and any value written to them is discarded.
- R3: A swap (valid and swap both high) returns the value the selected view held before the access, in the same cycle. The new value from the write data takes effect at the next clock edge.
- R4: A rounding-mode-view access (view code 1) reads the mode in bits 2..0 with all other bits zero. Its write takes only write-data bits 2..0 and leaves the flags alone.
- R5: A flag-view access (view code 2) reads the flags in bits 4..0 with all other bits zero. Its write takes only write-data bits 4..0 and leaves the rounding mode alone.
- R6: An access with swap low, or with valid low, changes no state. View code 3 reads as zero and writes nothing.
- R7: The flag bit positions are invalid=4, divide-by-zero=3, overflow=2, underflow=1 and inexact=0. Each cycle the flag input is ORed into the stored flags, and a flag stays set until a CSR write clears it.
- R8: When a full-view or flag-view swap happens in the same cycle as an accrual, the stored flags take the written value and the accrual is dropped. A rounding-mode-view swap does not block accrual.
- R9: The effective rounding mode equals the instruction's field for codes 000 to 110, and equals the stored dynamic mode for field 111. The mode codes are 000 nearest-even, 001 toward zero, 010 down, 011 up and 100 nearest with ties to max magnitude.
- R10: The illegal-encoding output is high for an instruction field of 101 or 110. It is also high for field 111 when the stored mode is 101, 110 or 111. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | CSR access present this cycle |
| acc_view | input | 2 | 0 full register, 1 rounding mode, 2 flags, 3 none |
| acc_swap | input | 1 | 1 swap (read old value, write new), 0 read only |
| acc_wdata | input | 32 | Source operand for a swap |
| acc_rdata | output | 32 | Prior value of the selected view |
| flag_in | input | 5 | Exception flags raised by the datapath this cycle |
| insn_rm | input | 3 | Instruction rounding-mode field |
| eff_rm | output | 3 | Resolved rounding mode |
| rm_illegal | output | 1 | Resolved mode is a reserved encoding |

## Verification
Random swaps go through all four views with random write data, including junk in the upper and unused bits. This separates field placement from field masking, and it shows up any leak between the mode and the flags. Random flag input runs alongside these accesses, and directed cycles put an accrual next to each kind of write, which isolates the write-over-accrual priority. Every instruction field value is tried against stored modes that are legal and stored modes that are reserved, so a static reserved code, a dynamic reserved code and a pass-through are each observed.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;

    localparam int RM_W = 3;
    localparam int FL_W = 5;
    localparam int FULL_W = RM_W + FL_W;

    typedef enum logic [1:0] {
        VIEW_FULL  = 2'd0,
        VIEW_RM    = 2'd1,
        VIEW_FLAGS = 2'd2,
        VIEW_NONE  = 2'd3
    } csr_view_e;

    typedef struct packed {
        logic [RM_W-1:0] frm;
        logic [FL_W-1:0] flags;
    } csr_state_t;

    localparam logic [RM_W-1:0] RM_DYNAMIC = 3'b111;

    function automatic logic rm_static_reserved(input logic [RM_W-1:0] code);
        return (code == 3'b101) || (code == 3'b110);
    endfunction

    function automatic logic rm_dyn_reserved(input logic [RM_W-1:0] code);
        return code >= 3'b101;
    endfunction

endpackage

// File: rtl/fcsr_store.sv
module fcsr_store
    import fcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_valid,
    input  csr_view_e       acc_view,
    input  logic            acc_swap,
    input  logic [XLEN-1:0] acc_wdata,
    input  logic [FL_W-1:0] flag_in,
    output logic [XLEN-1:0] acc_rdata,
    output csr_state_t      state
);

    csr_state_t state_q;
    logic       wr_rm;
    logic       wr_fl;
    logic [RM_W-1:0] new_rm;

    assign wr_rm = acc_valid && acc_swap &&
                   (acc_view == VIEW_FULL || acc_view == VIEW_RM);
    assign wr_fl = acc_valid && acc_swap &&
                   (acc_view == VIEW_FULL || acc_view == VIEW_FLAGS);
    assign new_rm = (acc_view == VIEW_FULL) ? acc_wdata[FL_W +: RM_W]
                                            : acc_wdata[RM_W-1:0];

    always_comb begin
        acc_rdata = '0;
        if (acc_valid) begin
            unique case (acc_view)
                VIEW_FULL:  acc_rdata = XLEN'(state_q);
                VIEW_RM:    acc_rdata = XLEN'(state_q.frm);
                VIEW_FLAGS: acc_rdata = XLEN'(state_q.flags);
                default:    acc_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            if (wr_rm) state_q.frm <= new_rm;
            if (wr_fl) state_q.flags <= acc_wdata[FL_W-1:0];
            else       state_q.flags <= state_q.flags | flag_in;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/fcsr_rm_resolve.sv
module fcsr_rm_resolve
    import fcsr_pkg::*;
(
    input  logic [RM_W-1:0] insn_rm,
    input  logic [RM_W-1:0] dyn_rm,
    output logic [RM_W-1:0] eff_rm,
    output logic            rm_illegal
);

    logic use_dyn;

    assign use_dyn = (insn_rm == RM_DYNAMIC);

    always_comb begin
        if (use_dyn) begin
            eff_rm     = dyn_rm;
            rm_illegal = rm_dyn_reserved(dyn_rm);
        end else begin
            eff_rm     = insn_rm;
            rm_illegal = rm_static_reserved(insn_rm);
        end
    end

endmodule

// File: rtl/fp_ctl_csr.sv
module fp_ctl_csr
    import fcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_valid,
    input  logic [1:0]      acc_view,
    input  logic            acc_swap,
    input  logic [XLEN-1:0] acc_wdata,
    output logic [XLEN-1:0] acc_rdata,
    input  logic [4:0]      flag_in,
    input  logic [2:0]      insn_rm,
    output logic [2:0]      eff_rm,
    output logic            rm_illegal
);

    csr_state_t cur_state;

    fcsr_store #(.XLEN(XLEN)) u_store (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_view  (csr_view_e'(acc_view)),
        .acc_swap  (acc_swap),
        .acc_wdata (acc_wdata),
        .flag_in   (flag_in),
        .acc_rdata (acc_rdata),
        .state     (cur_state)
    );

    fcsr_rm_resolve u_resolve (
        .insn_rm    (insn_rm),
        .dyn_rm     (cur_state.frm),
        .eff_rm     (eff_rm),
        .rm_illegal (rm_illegal)
    );

endmodule

// File: rtl/fp_ctl_csr_chk.sv
module fp_ctl_csr_chk
    import fcsr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic [1:0]  acc_view,
    input logic        acc_swap,
    input logic [31:0] acc_wdata,
    input logic [31:0] acc_rdata,
    input logic [4:0]  flag_in,
    input logic [2:0]  insn_rm,
    input logic [2:0]  eff_rm,
    input logic        rm_illegal,
    input csr_state_t  st
);

    logic wr_fl;
    assign wr_fl = acc_valid && acc_swap && (acc_view == 2'd0 || acc_view == 2'd2);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (st == '0)); // R1

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        acc_rdata[31:8] == 24'd0); // R2

    AST_FULL_SWAP_RM: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_swap && acc_view == 2'd0) |=> (st.frm == $past(acc_wdata[7:5]))); // R3

    AST_RM_VIEW_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_swap && acc_view == 2'd1 && flag_in == 5'd0) |=> $stable(st.flags)); // R4

    AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!(acc_valid && acc_swap) && flag_in == 5'd0) |=> $stable(st)); // R6

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !wr_fl |=> ((st.flags & $past(st.flags | flag_in)) == $past(st.flags | flag_in))); // R7

    AST_STATIC_RESERVED: assert property (@(posedge clk) disable iff (rst)
        (insn_rm == 3'b101 || insn_rm == 3'b110) |-> rm_illegal); // R10

    AST_DYN_PICK: assert property (@(posedge clk) disable iff (rst)
        (insn_rm == 3'b111) |-> (eff_rm == st.frm)); // R9

endmodule

bind fp_ctl_csr fp_ctl_csr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_view   (acc_view),
    .acc_swap   (acc_swap),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata),
    .flag_in    (flag_in),
    .insn_rm    (insn_rm),
    .eff_rm     (eff_rm),
    .rm_illegal (rm_illegal),
    .st         (cur_state)
);

// File: tb/test_fp_ctl_csr.sv
module test_fp_ctl_csr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_view = 2'd0;
    logic        acc_swap = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [4:0]  flag_in = '0;
    logic [2:0]  insn_rm = '0;
    logic [2:0]  eff_rm;
    logic        rm_illegal;

    int checks = 0;
    int errors = 0;

    logic [2:0] m_rm;
    logic [4:0] m_fl;

    always #4 clk = ~clk;

    fp_ctl_csr i_fp_ctl_csr (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_view(acc_view),
        .acc_swap(acc_swap), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .flag_in(flag_in), .insn_rm(insn_rm), .eff_rm(eff_rm), .rm_illegal(rm_illegal)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic v, input logic [1:0] vw);
        if (!v) return 32'd0;
        case (vw)
            2'd0: return {24'd0, m_rm, m_fl};
            2'd1: return {29'd0, m_rm};
            2'd2: return {27'd0, m_fl};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [2:0] exp_eff(input logic [2:0] ir);
        return (ir == 3'b111) ? m_rm : ir;
    endfunction

    function automatic logic exp_ill(input logic [2:0] ir);
        if (ir == 3'b111) return m_rm >= 3'b101;
        return (ir == 3'b101) || (ir == 3'b110);
    endfunction

    // One cycle: drive at the falling edge, check combinational outputs, advance the model.
    task automatic step(input string tag, input logic v, input logic [1:0] vw, input logic sw,
                        input logic [31:0] wd, input logic [4:0] fi, input logic [2:0] ir);
        @(negedge clk);
        acc_valid = v; acc_view = vw; acc_swap = sw; acc_wdata = wd;
        flag_in = fi; insn_rm = ir;
        #1;
        check({tag, " rdata"}, acc_rdata, exp_read(v, vw));
        check("R9 eff_rm", {29'd0, eff_rm}, {29'd0, exp_eff(ir)});
        check("R10 rm_illegal", {31'd0, rm_illegal}, {31'd0, exp_ill(ir)});
        if (v && sw && (vw == 2'd0)) m_rm = wd[7:5];
        else if (v && sw && (vw == 2'd1)) m_rm = wd[2:0];
        if (v && sw && (vw == 2'd0 || vw == 2'd2)) m_fl = wd[4:0];
        else m_fl = m_fl | fi;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_rm = '0; m_fl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset state
        step("R1 reset full read", 1, 2'd0, 0, 32'hFFFF_FFFF, 5'd0, 3'b000);
        // R2: upper bits discarded, fields placed
        step("R2 full swap junk", 1, 2'd0, 1, 32'hDEAD_BEAB, 5'd0, 3'b111);
        step("R2 full read", 1, 2'd0, 0, 32'h0, 5'd0, 3'b111);
        // R3: swap returns old, new value next cycle
        step("R3 swap old", 1, 2'd0, 1, 32'h0000_0060, 5'd0, 3'b111);
        step("R3 swap new", 1, 2'd0, 0, 32'h0, 5'd0, 3'b111);
        // R4: mode view
        step("R4 rm swap", 1, 2'd1, 1, 32'hFFFF_FFF9, 5'd0, 3'b111);
        step("R4 rm read", 1, 2'd1, 0, 32'h0, 5'd0, 3'b111);
        step("R4 flags untouched", 1, 2'd0, 0, 32'h0, 5'd0, 3'b010);
        // R5: flag view
        step("R5 fl swap", 1, 2'd2, 1, 32'hFFFF_FF35, 5'd0, 3'b110);
        step("R5 fl read", 1, 2'd2, 0, 32'h0, 5'd0, 3'b101);
        step("R5 rm untouched", 1, 2'd1, 0, 32'h0, 5'd0, 3'b111);
        // R6: no-write cases
        step("R6 invalid swap", 0, 2'd0, 1, 32'h0, 5'd0, 3'b000);
        step("R6 view3 swap", 1, 2'd3, 1, 32'h0, 5'd0, 3'b000);
        step("R6 after", 1, 2'd0, 0, 32'h0, 5'd0, 3'b000);
        // R7: accrual sticky
        step("R7 clear", 1, 2'd2, 1, 32'h0, 5'd0, 3'b000);
        step("R7 accrue inv", 1, 2'd2, 0, 32'h0, 5'b10000, 3'b000);
        step("R7 accrue nx", 1, 2'd2, 0, 32'h0, 5'b00001, 3'b000);
        step("R7 sticky", 1, 2'd2, 0, 32'h0, 5'd0, 3'b000);
        // R8: write beats accrual; mode write does not
        step("R8 fl write vs acc", 1, 2'd2, 1, 32'h0, 5'h1F, 3'b000);
        step("R8 after fl write", 1, 2'd2, 0, 32'h0, 5'd0, 3'b000);
        step("R8 full write vs acc", 1, 2'd0, 1, 32'h0000_0004, 5'h10, 3'b000);
        step("R8 rm write with acc", 1, 2'd1, 1, 32'h1, 5'b01000, 3'b000);
        step("R8 after rm write", 1, 2'd0, 0, 32'h0, 5'd0, 3'b000);
        // R9/R10: every field against legal and reserved stored modes
        for (int d = 0; d < 8; d++) begin
            step("R10 set dyn", 1, 2'd1, 1, 32'(d), 5'd0, 3'b000);
            for (int s = 0; s < 8; s++)
                step("R9 resolve", 0, 2'd0, 0, 32'h0, 5'd0, 3'(s));
        end
        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] w;
            w = $urandom;
            step("R3 random", 1'($urandom), 2'($urandom), 1'($urandom), w,
                 (($urandom % 4) == 0) ? 5'($urandom) : 5'd0, 3'($urandom));
        end
        // R1: reset again mid-run
        @(negedge clk); rst = 1'b1; acc_valid = 0; flag_in = 0;
        @(negedge clk); rst = 1'b0; m_rm = '0; m_fl = '0;
        step("R1 reset again", 1, 2'd0, 0, 32'h0, 5'd0, 3'b111);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule